// File: doc/BRIEF.md
# Converter Serial Frame Sequencer

This block is the target side of a three-wire serial link on a sampling converter. A master lowers an active-low select line and toggles a serial clock. The block answers with one fixed frame on a single data line. The frame is a run of leading zeros, then the conversion word, then zeros for as long as the master keeps clocking. The conversion word is 14 data bits followed by 2 sub-bits. A stand-in conversion source supplies the word in parallel.

While select is high the block is in shutdown. Its data line is released and all its internal state is cleared. When select falls, the block drives the line low and starts an acquisition phase. It counts falling edges of the serial clock. The count moves it into the conversion phase and then into shifting. The conversion word is captured once, at the end of the conversion phase, so a later change at the source cannot corrupt a frame that is being sent. Raising select at any moment abandons the frame at once.

Top module: `adc_frame_serializer`

## Requirements
- R1: While `cs_n_i` is 1, `dout_oe_o` is 0, `dout_o` is 0, `shdn_o` is 1 and both `acq_o` and `conv_o` are 0.
- R2: When `cs_n_i` falls, `dout_oe_o` becomes 1, `dout_o` is 0, `acq_o` becomes 1 and `shdn_o` becomes 0, all before any serial clock falling edge.
- R3: With select low, counting falling edges from 1: `acq_o` is 1 until falling edge 6, `conv_o` is 1 after edges 6 and 7, and neither is 1 from edge 8 onward.
- R4: After falling edges 1 to 7, `dout_o` is 0. After falling edge k, for k from 8 to 23, `dout_o` equals bit (23-k) of the captured 16-bit word. In that word, bit 15 is D13, the first bit sent, bits 15..2 are D13..D0, bit 1 is S1 and bit 0 is S0.
- R5: After falling edge 24 and any later edges while select stays low, `dout_o` is 0 and `dout_oe_o` stays 1. The captured word does not change.
- R6: The word sent is the value on `src_word_i` when falling edge 8 occurs. A change to `src_word_i` after that edge does not alter the bits sent. A change before it does.
- R7: A rise of `cs_n_i` at any edge count returns the block to the R1 state at once. The next fall of select starts a fresh frame that begins again with leading zeros and acquisition.
- R8: While select is low, `dout_o` changes only at falling edges of `sclk_i`. It holds its value across the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cs_n_i | input | 1 | Active-low select; high forces shutdown and clears state |
| sclk_i | input | 1 | Serial clock from the master |
| src_word_i | input | 16 | Conversion word from the stand-in source: D13..D0 then S1, S0 |
| dout_o | output | 1 | Serial data value |
| dout_oe_o | output | 1 | Drive enable for the data pad; 0 means high impedance |
| shdn_o | output | 1 | Shutdown phase flag |
| acq_o | output | 1 | Acquisition phase flag |
| conv_o | output | 1 | Conversion phase flag |

## Verification
On every cycle, the assertions check the following:
- the edge counter steps by one and saturates;
- the counter is cleared while select is high;
- the phase flags never overlap and hand over at edge 6;
- the captured word equals the source value at edge 8 and then holds;
- the line stays low in the leading and trailing parts of the frame.

Only the bench scenarios can show the rest:
- the full bit order of the frame against many word patterns;
- the effect of changing the source just before and just after the capture edge;
- aborts at several edge counts followed by a clean restart;
- the line value being unchanged between a falling edge and the next rising edge.

// File: rtl/afs_pkg.sv
package afs_pkg;

  typedef enum logic [2:0] {
    PH_SHDN,
    PH_ACQ,
    PH_CONV,
    PH_XFER,
    PH_TAIL
  } afs_phase_e;

  // Phase as a function of select and the number of falling edges seen.
  function automatic afs_phase_e phase_of(
    input logic        cs_n,
    input int unsigned edges,
    input int unsigned conv_at,
    input int unsigned lead,
    input int unsigned data_end
  );
    if (cs_n)                return PH_SHDN;
    else if (edges < conv_at)  return PH_ACQ;
    else if (edges < lead)     return PH_CONV;
    else if (edges < data_end) return PH_XFER;
    else                       return PH_TAIL;
  endfunction

  // Word bit index carried in frame slot p (slot p follows falling edge p+1),
  // or -1 when the slot carries a fill zero.
  function automatic int slot_to_bit(
    input int unsigned p,
    input int unsigned lead,
    input int unsigned word_w
  );
    int unsigned edge_no;
    edge_no = p + 1;
    if (edge_no < lead || edge_no >= lead + word_w) return -1;
    return int'(word_w - 1 - (edge_no - lead));
  endfunction

endpackage

// File: rtl/afs_edge_counter.sv
module afs_edge_counter #(
  parameter int FRAME_LEN = 24,
  parameter int CNT_W     = $clog2(FRAME_LEN + 1)
) (
  input  logic             cs_n_i,
  input  logic             sclk_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             sat_o
);

  localparam logic [CNT_W-1:0] CntMax = CNT_W'(FRAME_LEN);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(negedge sclk_i or posedge cs_n_i) begin
    if (cs_n_i)              cnt_q <= '0;
    else if (cnt_q != CntMax) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
  assign sat_o = (cnt_q == CntMax);

  // R7: select high holds the counter cleared
  a_r7_cnt_cleared: assert property (@(posedge sclk_i) cs_n_i |-> (cnt_q == '0));

  // R3: one step per falling edge below the limit
  a_r3_cnt_step: assert property (@(negedge sclk_i) disable iff (cs_n_i)
    (cnt_q != CntMax) |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R5: saturated count holds
  a_r5_cnt_hold: assert property (@(negedge sclk_i) disable iff (cs_n_i)
    sat_o |=> (cnt_q == CntMax));

endmodule

// File: rtl/afs_result_shadow.sv
module afs_result_shadow #(
  parameter int WORD_W = 16,
  parameter int LEAD   = 8,
  parameter int CNT_W  = 5
) (
  input  logic              cs_n_i,
  input  logic              sclk_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [WORD_W-1:0] src_word_i,
  output logic [WORD_W-1:0] shadow_o,
  output logic              capture_o
);

  localparam logic [CNT_W-1:0] CapAt = CNT_W'(LEAD - 1);

  logic [WORD_W-1:0] shadow_q;

  // The falling edge that moves the count from LEAD-1 to LEAD ends conversion.
  assign capture_o = (cnt_i == CapAt);

  always_ff @(negedge sclk_i or posedge cs_n_i) begin
    if (cs_n_i)         shadow_q <= '0;
    else if (capture_o) shadow_q <= src_word_i;
  end

  assign shadow_o = shadow_q;

  // R6: captured value is the source value at the capture edge
  a_r6_capture: assert property (@(negedge sclk_i) disable iff (cs_n_i)
    capture_o |=> (shadow_q == $past(src_word_i)));

  // R5, R6: once past the capture edge the word never changes
  a_r6_hold: assert property (@(negedge sclk_i) disable iff (cs_n_i)
    (cnt_i >= CNT_W'(LEAD)) |=> $stable(shadow_q));

endmodule

// File: rtl/afs_phase_decode.sv
module afs_phase_decode
  import afs_pkg::*;
#(
  parameter int CONV_AT  = 6,
  parameter int LEAD     = 8,
  parameter int DATA_END = 24,
  parameter int CNT_W    = 5
) (
  input  logic             cs_n_i,
  input  logic             sclk_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             shdn_o,
  output logic             acq_o,
  output logic             conv_o
);

  afs_phase_e phase;

  always_comb begin
    phase  = phase_of(cs_n_i, 32'(cnt_i), CONV_AT, LEAD, DATA_END);
    shdn_o = (phase == PH_SHDN);
    acq_o  = (phase == PH_ACQ);
    conv_o = (phase == PH_CONV);
  end

  // R3: phases never overlap
  a_r3_phase_excl: assert property (@(posedge sclk_i) disable iff (cs_n_i)
    $onehot0({acq_o, conv_o, shdn_o}));

  // R3: acquisition hands over to conversion on the sixth edge
  a_r3_handover: assert property (@(negedge sclk_i) disable iff (cs_n_i)
    (acq_o && cnt_i == CNT_W'(CONV_AT - 1)) |=> (conv_o && !acq_o));

  // R3: conversion starts only at the programmed count
  a_r3_conv_start: assert property (@(posedge sclk_i) disable iff (cs_n_i)
    $rose(conv_o) |-> (cnt_i == CNT_W'(CONV_AT)));

endmodule

// File: rtl/afs_bit_mux.sv
module afs_bit_mux
  import afs_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int LEAD      = 8,
  parameter int FRAME_LEN = 24,
  parameter int CNT_W     = 5
) (
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [WORD_W-1:0] shadow_i,
  output logic              bit_o
);

  logic [FRAME_LEN-1:0] slot_bits;

  for (genvar p = 0; p < FRAME_LEN; p++) begin : g_slot
    localparam int BitIdx = slot_to_bit(p, LEAD, WORD_W);
    if (BitIdx >= 0) begin : g_data
      assign slot_bits[p] = shadow_i[BitIdx];
    end else begin : g_fill
      assign slot_bits[p] = 1'b0;
    end
  end

  always_comb begin
    if (cnt_i == '0) bit_o = 1'b0;
    else             bit_o = slot_bits[cnt_i - 1'b1];
  end

endmodule

// File: rtl/adc_frame_serializer.sv
module adc_frame_serializer #(
  parameter int LEAD_ZEROS = 8,
  parameter int DATA_W     = 14,
  parameter int SUB_W      = 2,
  parameter int CONV_AT    = 6
) (
  input  logic                      cs_n_i,
  input  logic                      sclk_i,
  input  logic [DATA_W+SUB_W-1:0]   src_word_i,
  output logic                      dout_o,
  output logic                      dout_oe_o,
  output logic                      shdn_o,
  output logic                      acq_o,
  output logic                      conv_o
);

  localparam int WORD_W    = DATA_W + SUB_W;
  localparam int FRAME_LEN = LEAD_ZEROS + WORD_W;
  localparam int CNT_W     = $clog2(FRAME_LEN + 1);

  logic [CNT_W-1:0]  edge_cnt;
  logic              cnt_sat;
  logic [WORD_W-1:0] held_word;
  logic              word_capture;
  logic              frame_bit;

  afs_edge_counter #(
    .FRAME_LEN(FRAME_LEN),
    .CNT_W    (CNT_W)
  ) u_cnt (
    .cs_n_i(cs_n_i),
    .sclk_i(sclk_i),
    .cnt_o (edge_cnt),
    .sat_o (cnt_sat)
  );

  afs_result_shadow #(
    .WORD_W(WORD_W),
    .LEAD  (LEAD_ZEROS),
    .CNT_W (CNT_W)
  ) u_shadow (
    .cs_n_i    (cs_n_i),
    .sclk_i    (sclk_i),
    .cnt_i     (edge_cnt),
    .src_word_i(src_word_i),
    .shadow_o  (held_word),
    .capture_o (word_capture)
  );

  afs_phase_decode #(
    .CONV_AT (CONV_AT),
    .LEAD    (LEAD_ZEROS),
    .DATA_END(FRAME_LEN),
    .CNT_W   (CNT_W)
  ) u_phase (
    .cs_n_i(cs_n_i),
    .sclk_i(sclk_i),
    .cnt_i (edge_cnt),
    .shdn_o(shdn_o),
    .acq_o (acq_o),
    .conv_o(conv_o)
  );

  afs_bit_mux #(
    .WORD_W   (WORD_W),
    .LEAD     (LEAD_ZEROS),
    .FRAME_LEN(FRAME_LEN),
    .CNT_W    (CNT_W)
  ) u_mux (
    .cnt_i   (edge_cnt),
    .shadow_i(held_word),
    .bit_o   (frame_bit)
  );

  assign dout_oe_o = !cs_n_i;
  assign dout_o    = dout_oe_o & frame_bit;

  // R4: leading part of the frame is driven low
  a_r4_lead_low: assert property (@(posedge sclk_i) disable iff (cs_n_i)
    (edge_cnt < CNT_W'(LEAD_ZEROS)) |-> (dout_oe_o && !dout_o));

  // R5: trailing part of the frame is driven low
  a_r5_tail_low: assert property (@(posedge sclk_i) disable iff (cs_n_i)
    cnt_sat |-> (dout_oe_o && !dout_o));

  // R6: capture never happens once the frame has left conversion
  a_r6_single_capture: assert property (@(posedge sclk_i) disable iff (cs_n_i)
    word_capture |-> conv_o);

endmodule

// File: tb/adc_frame_serializer_bench.sv
module adc_frame_serializer_bench;

  localparam int LEAD  = 8;
  localparam int WLEN  = 16;
  localparam int CONV  = 6;

  logic        cs_n;
  logic        sclk;
  logic [15:0] src;
  logic        dout, dout_oe, shdn, acq, conv;

  int errs   = 0;
  int checks = 0;
  bit done   = 0;

  adc_frame_serializer u_adc_frame_serializer (
    .cs_n_i    (cs_n),
    .sclk_i    (sclk),
    .src_word_i(src),
    .dout_o    (dout),
    .dout_oe_o (dout_oe),
    .shdn_o    (shdn),
    .acq_o     (acq),
    .conv_o    (conv)
  );

  initial sclk = 1'b0;
  always #10 sclk = ~sclk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Bit sent after falling edge k for word w, from the frame layout.
  function automatic int exp_bit(input int k, input logic [15:0] w);
    int pos;
    pos = k - LEAD;
    if (pos < 0 || pos >= WLEN) return 0;
    return int'((w >> (WLEN - 1 - pos)) & 16'h1);
  endfunction

  task automatic chk_idle(input string req);
    chk(dout_oe == 1'b0, req, int'(dout_oe), 0);
    chk(dout == 1'b0,    req, int'(dout), 0);
    chk(shdn == 1'b1,    req, int'(shdn), 1);
    chk({acq, conv} == 2'b00, req, int'({acq, conv}), 0);
  endtask

  // One frame: nedges falling edges, optional source change after edge chg_k,
  // optional abort after edge abort_k (0 = none).
  task automatic run_frame(input logic [15:0] w, input int nedges,
                           input int chg_k, input logic [15:0] w2,
                           input int abort_k);
    logic [15:0] sent;
    logic        early;
    src  = w;
    sent = (chg_k > 0 && chg_k < LEAD) ? w2 : w;
    @(posedge sclk); #5;
    chk_idle("R1");
    cs_n = 1'b0;
    #1;
    chk(dout_oe == 1'b1, "R2", int'(dout_oe), 1);
    chk(dout == 1'b0,    "R2", int'(dout), 0);
    chk(acq == 1'b1 && shdn == 1'b0, "R2", int'({acq, shdn}), 2);
    for (int k = 1; k <= nedges; k++) begin
      @(negedge sclk); #3;
      early = dout;
      chk(int'(dout) == exp_bit(k, sent), (k >= LEAD + WLEN) ? "R5" : "R4",
          int'(dout), exp_bit(k, sent));
      chk(acq == (k < CONV), "R3", int'(acq), int'(k < CONV));
      chk(conv == (k >= CONV && k < LEAD), "R3", int'(conv), int'(k >= CONV && k < LEAD));
      chk(dout_oe == 1'b1, "R5", int'(dout_oe), 1);
      if (k == chg_k) src = w2;
      #10;
      chk(dout == early, "R8", int'(dout), int'(early));
      if (k == abort_k) begin
        cs_n = 1'b1;
        #1;
        chk_idle("R7");
        break;
      end
    end
    cs_n = 1'b1;
    #1;
    chk_idle("R1");
    repeat (2) @(posedge sclk);
  endtask

  initial begin
    cs_n = 1'b1;
    src  = '0;
    repeat (3) @(posedge sclk);
    #5;
    chk_idle("R1");

    for (int i = 0; i < 16; i++) run_frame(16'h1 << i, 28, 0, '0, 0);
    for (int i = 0; i < 16; i++) run_frame(~(16'h1 << i), 26, 0, '0, 0);
    run_frame(16'h0000, 24, 0, '0, 0);
    run_frame(16'hFFFF, 30, 0, '0, 0);
    run_frame(16'hAAAA, 25, 0, '0, 0);
    run_frame(16'h5555, 25, 0, '0, 0);
    for (int i = 1; i <= 24; i++) run_frame(16'(i * 4099), 25, 0, '0, 0);

    // R6: change after the capture edge is ignored; before it is taken
    run_frame(16'hC3A5, 26, 12, 16'h3C5A, 0);
    run_frame(16'hC3A5, 26, 8, 16'h0FF0, 0);
    run_frame(16'hC3A5, 26, 7, 16'h3C5A, 0);
    run_frame(16'h1234, 26, 3, 16'hFEDC, 0);

    // R7: aborts in each phase, each followed by a fresh frame
    run_frame(16'hFFFF, 26, 0, '0, 3);
    run_frame(16'hB00B, 26, 0, '0, 0);
    run_frame(16'hFFFF, 26, 0, '0, 7);
    run_frame(16'hFFFF, 26, 0, '0, 0);
    run_frame(16'hFFFF, 26, 0, '0, 12);
    run_frame(16'h8001, 26, 0, '0, 0);
    run_frame(16'hFFFF, 30, 0, '0, 27);
    run_frame(16'h7FFE, 24, 0, '0, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule